// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial line into data words and stores them in a small receive queue. Each stored word carries two tags: one for a bad stop bit and one for a parity mismatch. Frames with errors are still stored, so software can tell exactly which words are suspect while reception goes on without a break. The line input must already be synchronised to `clk`. The sampling rate comes from an external enable pulse (`baudTick`), with a fixed number of pulses per bit. Configuration inputs select:
- parity on or off, and odd or even parity;
- 7 or 8 data bits;
- one or two stop bits.

Software reads the oldest word and its tags from the head outputs and removes it with a pop strobe. A status word holds two sticky bits: a summary receive-error bit and a queue-overrun bit. Each bit clears only through a two-step handshake. Software first reads the bit while it is 1, then writes 0 to it. The summary error bit also serves as a level interrupt, and `rxReady` signals that the queue is not empty.

Top module: `rx_tagged_fifo`

## Requirements
- R1: After reset the queue is empty (`fifoCount` = 0, `rxReady` = 0), and `statusErr` and `statusOverrun` are both 0.
- R2: A falling line is accepted as a start bit only if the line is still low when re-sampled half a bit later (8 ticks out of 16). Otherwise the receiver returns to idle and nothing is stored.
- R3: Data bits arrive LSB first. With `cfgEightBit`=1 a word has 8 bits. With `cfgEightBit`=0 it has 7 bits, and bit 7 of the stored word reads 0.
- R4: With `cfgParityEn`=1, a bit follows the data bits. The parity tag is set when the number of ones across the data bits and this bit is odd under even parity (`cfgParityOdd`=0), or even under odd parity (`cfgParityOdd`=1).
- R5: The framing tag is set when the first stop bit, sampled mid-bit, is 0.
- R6: In two-stop mode (`cfgTwoStop`=1) the second stop bit is never checked, so a 0 there raises no error.
- R7: A frame with an error is still written to the queue with its tags, and the frame that follows is received normally.
- R8: `statusErr` (status bit 0) is set by any framing or parity error and stays set until cleared.
- R9: A status bit clears only when a `statusWrite` with that bit 0 follows a `statusRead` that returned it as 1. A 0 written without that prior read, or a 1 written at any time, leaves the bit unchanged. Any write disarms the pending clear.
- R10: While `rxEnable` is 0 no frame is received, and the status bits keep their values.
- R11: A frame that completes while the queue holds `FIFO_DEPTH` words is dropped, the stored words are left intact, and `statusOverrun` (status bit 1) is set. This bit is sticky and is cleared by the same handshake as R9.
- R12: `popEntry` removes the head word when the queue is not empty. On an empty queue it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| rxLine | input | 1 | Synchronised serial line, idle high |
| baudTick | input | 1 | Sampling enable, TICKS_PER_BIT pulses per bit |
| rxEnable | input | 1 | Receiver enable |
| cfgParityEn | input | 1 | Parity bit present and checked |
| cfgParityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| cfgEightBit | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfgTwoStop | input | 1 | 1 = two stop bits |
| popEntry | input | 1 | Remove head word |
| statusRead | input | 1 | Software read of the status bits (arms a clear) |
| statusWrite | input | 1 | Software write of the status bits |
| statusWrData | input | 2 | Write data: bit 0 error, bit 1 overrun |
| headData | output | DATA_W | Oldest stored word |
| headFramingErr | output | 1 | Framing tag of the head word |
| headParityErr | output | 1 | Parity tag of the head word |
| fifoCount | output | clog2(FIFO_DEPTH+1) | Number of stored words |
| rxReady | output | 1 | Queue not empty |
| statusErr | output | 1 | Sticky summary receive error (level interrupt) |
| statusOverrun | output | 1 | Sticky queue overrun |

## Verification
The bench builds the block with a queue depth of 4 instead of 16, so five back-to-back frames are enough to reach the overrun path and to check that the stored head survives a dropped frame. `TICKS_PER_BIT` stays at 16, with `baudTick` pulsing every second clock. With these values the mid-bit sample point, and the false start seen after a low stop bit, fall at known offsets into each bit. The bench covers both data lengths, both parity senses and both stop modes.

// File: rtl/rx_tagged_pkg.sv
package rx_tagged_pkg;

  // strobes the control sends to the datapath
  typedef struct packed {
    logic clearAcc;    // start bit confirmed: reset parity accumulator
    logic shiftBit;    // mid-bit sample of a data bit
    logic takeParity;  // mid-bit sample of the parity bit
    logic commit;      // mid-bit sample of the first stop bit: frame done
  } rxStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } rxState_t;

endpackage

// File: rtl/rx_tagged_ctrl.sv
module rx_tagged_ctrl
  import rx_tagged_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  logic       baudTick,
  input  logic       rxEnable,
  input  logic       cfgParityEn,
  input  logic       cfgEightBit,
  input  logic       cfgTwoStop,
  output rxStrobe_t  strobe
);

  localparam int TW   = $clog2(TICKS_PER_BIT);
  localparam int HALF = TICKS_PER_BIT / 2;
  localparam int BW   = $clog2(DATA_W);

  rxState_t        state;
  logic [TW-1:0]   tickCnt;
  logic [BW-1:0]   bitCnt;
  logic [BW-1:0]   lastBit;
  logic            bitDone;
  logic            halfDone;

  assign lastBit  = cfgEightBit ? BW'(DATA_W - 1) : BW'(DATA_W - 2);
  assign bitDone  = baudTick && (tickCnt == TW'(TICKS_PER_BIT - 1));
  assign halfDone = baudTick && (tickCnt == TW'(HALF - 1));

  always_comb begin
    strobe            = '0;
    strobe.clearAcc   = rxEnable && (state == ST_START)  && halfDone && !rxLine;
    strobe.shiftBit   = rxEnable && (state == ST_DATA)   && bitDone;
    strobe.takeParity = rxEnable && (state == ST_PARITY) && bitDone;
    strobe.commit     = rxEnable && (state == ST_STOP1)  && bitDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (!rxEnable) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
    end else if (baudTick) begin
      case (state)
        ST_IDLE: begin
          if (!rxLine) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (halfDone) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= rxLine ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + TW'(1);
          end
        end
        ST_DATA: begin
          if (bitDone) begin
            tickCnt <= '0;
            if (bitCnt == lastBit) begin
              state <= cfgParityEn ? ST_PARITY : ST_STOP1;
            end else begin
              bitCnt <= bitCnt + BW'(1);
            end
          end else begin
            tickCnt <= tickCnt + TW'(1);
          end
        end
        ST_PARITY: begin
          if (bitDone) begin
            tickCnt <= '0;
            state   <= ST_STOP1;
          end else begin
            tickCnt <= tickCnt + TW'(1);
          end
        end
        ST_STOP1: begin
          if (bitDone) begin
            tickCnt <= '0;
            state   <= cfgTwoStop ? ST_STOP2 : ST_IDLE;
          end else begin
            tickCnt <= tickCnt + TW'(1);
          end
        end
        ST_STOP2: begin
          // second stop bit is only waited out, never checked
          if (bitDone) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + TW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_tagged_dp.sv
module rx_tagged_dp
  import rx_tagged_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  rxStrobe_t         strobe,
  input  logic              cfgEightBit,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              popEntry,
  input  logic              statusRead,
  input  logic              statusWrite,
  input  logic [1:0]        statusWrData,
  output logic [DATA_W-1:0] headData,
  output logic              headFramingErr,
  output logic              headParityErr,
  output logic [CW-1:0]     fifoCount,
  output logic              statusErr,
  output logic              statusOverrun
);

  localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int EW = DATA_W + 2;

  // frame assembly
  logic [DATA_W-1:0] shiftReg;
  logic              parAcc;
  logic              parBit;
  logic [DATA_W-1:0] frameData;
  logic              frameFer;
  logic              framePer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
    end else begin
      if (strobe.clearAcc) parAcc <= 1'b0;
      if (strobe.shiftBit) begin
        shiftReg <= {rxLine, shiftReg[DATA_W-1:1]};
        parAcc   <= parAcc ^ rxLine;
      end
      if (strobe.takeParity) parBit <= rxLine;
    end
  end

  assign frameData = cfgEightBit ? shiftReg : {1'b0, shiftReg[DATA_W-1:1]};
  assign frameFer  = !rxLine;
  assign framePer  = cfgParityEn && ((parAcc ^ parBit) != cfgParityOdd);

  // receive queue
  logic [EW-1:0] mem [FIFO_DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          isFull, isEmpty, doPush, doPop, dropFrame;

  assign isFull    = (fifoCount == CW'(FIFO_DEPTH));
  assign isEmpty   = (fifoCount == '0);
  assign doPush    = strobe.commit && !isFull;
  assign dropFrame = strobe.commit && isFull;
  assign doPop     = popEntry && !isEmpty;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(FIFO_DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {frameFer, framePer, frameData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   fifoCount <= fifoCount + CW'(1);
        2'b01:   fifoCount <= fifoCount - CW'(1);
        default: fifoCount <= fifoCount;
      endcase
    end
  end

  assign {headFramingErr, headParityErr, headData} = mem[rdPtr];

  // sticky status bits with read-1-then-write-0 clear
  logic [1:0] flagSet, flagNow, flagArm;

  assign flagSet = {dropFrame, strobe.commit && (frameFer || framePer)};
  assign flagNow = {statusOverrun, statusErr};

  logic [1:0] flagNext;
  generate
    for (genvar b = 0; b < 2; b++) begin : g_flag
      always_comb begin
        if (flagSet[b])
          flagNext[b] = 1'b1;
        else if (statusWrite && !statusWrData[b] && flagArm[b])
          flagNext[b] = 1'b0;
        else
          flagNext[b] = flagNow[b];
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            flagArm[b] <= 1'b0;
        else if (statusWrite) flagArm[b] <= 1'b0;
        else if (statusRead)  flagArm[b] <= flagNow[b];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusErr     <= 1'b0;
      statusOverrun <= 1'b0;
    end else begin
      statusErr     <= flagNext[0];
      statusOverrun <= flagNext[1];
    end
  end

endmodule

// File: rtl/rx_tagged_fifo.sv
module rx_tagged_fifo
  import rx_tagged_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8,
  parameter int FIFO_DEPTH    = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             rxLine,
  input  logic                             baudTick,
  input  logic                             rxEnable,
  input  logic                             cfgParityEn,
  input  logic                             cfgParityOdd,
  input  logic                             cfgEightBit,
  input  logic                             cfgTwoStop,
  input  logic                             popEntry,
  input  logic                             statusRead,
  input  logic                             statusWrite,
  input  logic [1:0]                       statusWrData,
  output logic [DATA_W-1:0]                headData,
  output logic                             headFramingErr,
  output logic                             headParityErr,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]  fifoCount,
  output logic                             rxReady,
  output logic                             statusErr,
  output logic                             statusOverrun
);

  rxStrobe_t strobe;
  logic      frameCommit;

  assign frameCommit = strobe.commit;
  assign rxReady     = (fifoCount != '0);

  rx_tagged_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .DATA_W       (DATA_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .baudTick   (baudTick),
    .rxEnable   (rxEnable),
    .cfgParityEn(cfgParityEn),
    .cfgEightBit(cfgEightBit),
    .cfgTwoStop (cfgTwoStop),
    .strobe     (strobe)
  );

  rx_tagged_dp #(
    .DATA_W    (DATA_W),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .rxLine        (rxLine),
    .strobe        (strobe),
    .cfgEightBit   (cfgEightBit),
    .cfgParityEn   (cfgParityEn),
    .cfgParityOdd  (cfgParityOdd),
    .popEntry      (popEntry),
    .statusRead    (statusRead),
    .statusWrite   (statusWrite),
    .statusWrData  (statusWrData),
    .headData      (headData),
    .headFramingErr(headFramingErr),
    .headParityErr (headParityErr),
    .fifoCount     (fifoCount),
    .statusErr     (statusErr),
    .statusOverrun (statusOverrun)
  );

endmodule

// File: rtl/rx_tagged_chk.sv
module rx_tagged_chk #(
  parameter int FIFO_DEPTH = 16,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          popEntry,
  input logic          statusWrite,
  input logic [1:0]    statusWrData,
  input logic [CW-1:0] fifoCount,
  input logic          statusErr,
  input logic          statusOverrun,
  input logic          frameCommit
);

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CW'(FIFO_DEPTH));

  assert_overrun_on_full_R11: assert property (@(posedge clk) disable iff (!rstN)
    (frameCommit && fifoCount == CW'(FIFO_DEPTH)) |=> statusOverrun);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusErr && !statusWrite) |=> statusErr);

  assert_clear_needs_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusErr) |-> $past(statusWrite && !statusWrData[0]));

  assert_ovr_clear_needs_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusOverrun) |-> $past(statusWrite && !statusWrData[1]));

  assert_pop_R12: assert property (@(posedge clk) disable iff (!rstN)
    (popEntry && fifoCount != '0 && !frameCommit) |=> fifoCount == $past(fifoCount) - CW'(1));

  assert_empty_pop_R12: assert property (@(posedge clk) disable iff (!rstN)
    (popEntry && fifoCount == '0 && !frameCommit) |=> fifoCount == '0);

endmodule

bind rx_tagged_fifo rx_tagged_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .popEntry     (popEntry),
  .statusWrite  (statusWrite),
  .statusWrData (statusWrData),
  .fifoCount    (fifoCount),
  .statusErr    (statusErr),
  .statusOverrun(statusOverrun),
  .frameCommit  (frameCommit)
);

// File: tb/rx_tagged_fifo_tb_top.sv
module rx_tagged_fifo_tb_top;

  localparam int DEPTH   = 4;
  localparam int CLK_PER_BIT = 32;  // 16 ticks, one tick every 2 clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       baudTick = 1'b0;
  logic       rxEnable = 1'b0;
  logic       cfgParityEn = 1'b0;
  logic       cfgParityOdd = 1'b0;
  logic       cfgEightBit = 1'b1;
  logic       cfgTwoStop = 1'b0;
  logic       popEntry = 1'b0;
  logic       statusRead = 1'b0;
  logic       statusWrite = 1'b0;
  logic [1:0] statusWrData = 2'b00;
  logic [7:0] headData;
  logic       headFramingErr, headParityErr;
  logic [2:0] fifoCount;
  logic       rxReady, statusErr, statusOverrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  rx_tagged_fifo #(.TICKS_PER_BIT(16), .DATA_W(8), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudTick(baudTick), .rxEnable(rxEnable),
    .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd), .cfgEightBit(cfgEightBit),
    .cfgTwoStop(cfgTwoStop), .popEntry(popEntry), .statusRead(statusRead),
    .statusWrite(statusWrite), .statusWrData(statusWrData), .headData(headData),
    .headFramingErr(headFramingErr), .headParityErr(headParityErr), .fifoCount(fifoCount),
    .rxReady(rxReady), .statusErr(statusErr), .statusOverrun(statusOverrun)
  );

  initial forever begin
    @(negedge clk);
    baudTick = ~baudTick;
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic holdBit(input logic v);
    rxLine = v;
    repeat (CLK_PER_BIT) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit badPar, input bit stop1, input bit stop2);
    int nb;
    logic ones;
    nb = cfgEightBit ? 8 : 7;
    ones = 1'b0;
    holdBit(1'b0);
    for (int i = 0; i < nb; i++) begin
      holdBit(d[i]);
      ones = ones ^ d[i];
    end
    if (cfgParityEn) holdBit(ones ^ cfgParityOdd ^ badPar);
    holdBit(stop1);
    if (cfgTwoStop) holdBit(stop2);
    holdBit(1'b1);
  endtask

  task automatic pulsePop();
    popEntry = 1'b1; @(negedge clk); popEntry = 1'b0; @(negedge clk);
  endtask

  task automatic doRead();
    statusRead = 1'b1; @(negedge clk); statusRead = 1'b0; @(negedge clk);
  endtask

  task automatic doWrite(input logic [1:0] v);
    statusWrData = v; statusWrite = 1'b1; @(negedge clk);
    statusWrite = 1'b0; @(negedge clk);
  endtask

  task automatic checkHead(input string req, input int d, input int fer, input int per);
    check({req, " data"}, headData, d);
    check({req, " framing tag"}, headFramingErr, fer);
    check({req, " parity tag"}, headParityErr, per);
  endtask

  task automatic clearErr();
    doRead(); doWrite(2'b00);
  endtask

  task automatic drain();
    while (fifoCount != 0) pulsePop();
  endtask

  // R1
  task automatic testReset();
    check("R1 count", fifoCount, 0);
    check("R1 ready", rxReady, 0);
    check("R1 err", statusErr, 0);
    check("R1 overrun", statusOverrun, 0);
  endtask

  // R3 and R12
  task automatic testBasic();
    cfgEightBit = 1; cfgParityEn = 0; cfgTwoStop = 0;
    sendFrame(8'hA5, 0, 1, 1);
    check("R3 count", fifoCount, 1);
    check("R3 ready", rxReady, 1);
    checkHead("R3 8N1", 8'hA5, 0, 0);
    pulsePop();
    check("R12 pop", fifoCount, 0);
    pulsePop();
    check("R12 pop on empty", fifoCount, 0);
    cfgEightBit = 0; cfgParityEn = 1; cfgParityOdd = 0;
    sendFrame(8'hB5, 0, 1, 1);
    checkHead("R3 seven bit even parity", 8'h35, 0, 0);
    check("R4 no error flag", statusErr, 0);
    drain();
  endtask

  // R4 R7 R8
  task automatic testParity();
    cfgEightBit = 1; cfgParityEn = 1; cfgParityOdd = 1;
    sendFrame(8'h3C, 0, 1, 1);
    sendFrame(8'h81, 1, 1, 1);
    sendFrame(8'h77, 0, 1, 1);
    check("R7 count after error", fifoCount, 3);
    check("R8 err set by parity", statusErr, 1);
    checkHead("R4 odd good", 8'h3C, 0, 0);
    pulsePop();
    checkHead("R4 odd bad", 8'h81, 0, 1);
    pulsePop();
    checkHead("R7 next frame", 8'h77, 0, 0);
    pulsePop();
    cfgParityEn = 0;
  endtask

  // R9
  task automatic testHandshake();
    doWrite(2'b00);
    check("R9 write0 without read", statusErr, 1);
    doRead(); doWrite(2'b01);
    check("R9 write1 after read", statusErr, 1);
    doWrite(2'b00);
    check("R9 write disarms", statusErr, 1);
    doRead(); doWrite(2'b00);
    check("R9 read1 then write0", statusErr, 0);
  endtask

  // R5 R8
  task automatic testFraming();
    cfgEightBit = 1; cfgParityEn = 0; cfgTwoStop = 0;
    sendFrame(8'h0F, 0, 0, 1);
    check("R5 count", fifoCount, 1);
    checkHead("R5 bad stop", 8'h0F, 1, 0);
    check("R8 err set by framing", statusErr, 1);
    pulsePop();
    clearErr();
    check("R9 cleared", statusErr, 0);
  endtask

  // R6
  task automatic testTwoStop();
    cfgTwoStop = 1;
    sendFrame(8'h5A, 0, 1, 0);
    check("R6 count", fifoCount, 1);
    checkHead("R6 second stop low", 8'h5A, 0, 0);
    check("R6 no err", statusErr, 0);
    pulsePop();
    sendFrame(8'hC3, 0, 0, 1);
    checkHead("R6 first stop low", 8'hC3, 1, 0);
    pulsePop();
    clearErr();
    cfgTwoStop = 0;
  endtask

  // R2
  task automatic testGlitch();
    rxLine = 1'b0;
    repeat (8) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * CLK_PER_BIT) @(negedge clk);
    check("R2 glitch ignored", fifoCount, 0);
  endtask

  // R10
  task automatic testDisable();
    sendFrame(8'h44, 0, 0, 1);
    pulsePop();
    rxEnable = 0;
    repeat (4) @(negedge clk);
    check("R10 flag kept", statusErr, 1);
    sendFrame(8'h12, 0, 1, 1);
    check("R10 no frame while off", fifoCount, 0);
    check("R10 flag still kept", statusErr, 1);
    rxEnable = 1;
    repeat (4) @(negedge clk);
    clearErr();
  endtask

  // R11
  task automatic testOverrun();
    for (int i = 0; i < DEPTH; i++) sendFrame(8'h10 + 8'(i), 0, 1, 1);
    check("R11 full", fifoCount, DEPTH);
    check("R11 no overrun yet", statusOverrun, 0);
    sendFrame(8'h99, 0, 1, 1);
    check("R11 count kept", fifoCount, DEPTH);
    check("R11 overrun set", statusOverrun, 1);
    checkHead("R11 head intact", 8'h10, 0, 0);
    pulsePop();
    checkHead("R11 second", 8'h11, 0, 0);
    doWrite(2'b00);
    check("R11 write without read", statusOverrun, 1);
    doRead(); doWrite(2'b00);
    check("R11 overrun cleared", statusOverrun, 0);
    drain();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    rxEnable = 1'b1;
    repeat (4) @(negedge clk);
    testBasic();
    testParity();
    testHandshake();
    testFraming();
    testTwoStop();
    testGlitch();
    testDisable();
    testOverrun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule